// File: doc/BRIEF.md
# External-Fault Hold Stretcher

This block turns short detection pulses from two external-fault detectors into a steady hold flag. The hold flag desensitises a line differential element. Each accepted pulse loads two dropout timers at the same time. The short timer sets a minimum hold that nothing can end early. The long timer rides through fast reclosing sequences. Time is counted in sample strobes, and one power cycle is `SPC` strobes.

The long timer can be cut short by a supervised release. Release needs three conditions:
- The filtered restraint is above a fixed floor.
- The differential magnitude is small against the restraint.
- The summed 2nd/4th/5th harmonic magnitude is small against the restraint.

Release also needs proof that saturation really occurred during the current hold. That proof is a full power cycle in which restraint is above the floor and both the differential and the harmonic sum are large. The release must then persist for a pickup interval, and it can only time while a hold is active. Evidence and pickup progress are discarded whenever the hold drops. A fresh detection always restarts both timers, including after a cancel.

Top module: `fault_hold`

## Requirements
- R1: A detection pulse on `det_ac` or `det_dc` is accepted on a clock edge where `sample_en` is 1. It loads both timers, and `hold` is 1 after that edge. `hold` is 1 exactly while either timer is non-zero.
- R2: The short timer keeps `hold` at 1 for `SHORT_CYC*SPC` strobes after the last accepted pulse. A long-timer cancel never shortens it.
- R3: Without a cancel, `hold` stays 1 for exactly `LONG_CYC*SPC` strobes after an accepted pulse. The loading edge counts as the first strobe, and `hold` falls on the next strobe after that.
- R4: On edges with `sample_en` = 0, pulses are ignored, and neither `hold` nor `long_cxl` changes.
- R5: Release is possible only while `irst_mag` is strictly greater than `FLOOR`.
- R6: Release is possible only while both `idif_mag` and `iharm_sum` are strictly below the threshold `(irst_mag*K_NUM)>>K_SH`. With the defaults, that threshold is 13/128 of the restraint.
- R7: Saturation evidence is latched only after `EVID_CYC*SPC` consecutive strobes, during a hold, in which restraint exceeds `FLOOR` and both `idif_mag` and `iharm_sum` exceed the threshold. Release is impossible without this evidence.
- R8: Release must hold for `PICK_CYC*SPC` consecutive strobes during a hold. An interrupted run starts its count again. On the final strobe, the long timer is cleared and `long_cxl` becomes 1.
- R9: An accepted pulse clears `long_cxl` and reloads both timers. This includes the edge on which a cancel would otherwise complete, because the pulse takes priority.
- R10: The evidence latch and the pickup count are cleared while `hold` is 0. Evidence from an earlier hold therefore does not allow release in a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | Sample strobe; all timing advances on it |
| det_ac | input | 1 | Detection pulse, first detection path |
| det_dc | input | 1 | Detection pulse, second detection path |
| irst_mag | input | MAG_W | Filtered restraining-current magnitude |
| idif_mag | input | MAG_W | Differential-current magnitude |
| iharm_sum | input | MAG_W | Sum of 2nd, 4th and 5th harmonic magnitudes of the differential current |
| hold | output | 1 | Element desensitised while 1 |
| long_cxl | output | 1 | Long timer was cancelled since the last accepted pulse |

## Verification
Two events can fall on the same strobe: the pickup interval completing, which cancels the long timer, and a new detection pulse, which reloads it. The bench builds up evidence and a full pickup run, then raises a detection pulse on exactly the completing strobe. The expected result is that the pulse wins: `long_cxl` stays 0, and `hold` outlives the short timer of that pulse. A second overlap is also exercised. In that case, a cancel lands while a recent pulse still has its short timer running, and the expected `hold` fall is the short timer's own end.

// File: rtl/fault_hold.sv
module fault_hold #(
  parameter int MAG_W     = 16,
  parameter int SPC       = 64,
  parameter int SHORT_CYC = 3,
  parameter int LONG_CYC  = 60,
  parameter int PICK_CYC  = 3,
  parameter int EVID_CYC  = 1,
  parameter int FLOOR     = 200,
  parameter int K_NUM     = 13,
  parameter int K_SH      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             det_ac,
  input  logic             det_dc,
  input  logic [MAG_W-1:0] irst_mag,
  input  logic [MAG_W-1:0] idif_mag,
  input  logic [MAG_W-1:0] iharm_sum,
  output logic             hold,
  output logic             long_cxl
);
  localparam int SHORT_N = SHORT_CYC * SPC;
  localparam int LONG_N  = LONG_CYC * SPC;
  localparam int PICK_N  = PICK_CYC * SPC;
  localparam int EVID_N  = EVID_CYC * SPC;
  localparam int SW  = $clog2(SHORT_N + 1);
  localparam int LW  = $clog2(LONG_N + 1);
  localparam int PW  = $clog2(PICK_N + 1);
  localparam int EW  = $clog2(EVID_N + 1);
  localparam int PRW = MAG_W + $clog2(K_NUM + 1);
  localparam logic [MAG_W-1:0] FLOOR_V = MAG_W'(FLOOR);

  logic [SW-1:0] short_cnt;
  logic [LW-1:0] long_cnt;
  logic [PW-1:0] pk_cnt;
  logic [EW-1:0] ev_cnt;
  logic          evid;
  logic          cxl_q;

  logic [PRW-1:0] prod, thr, dif_x, harm_x;
  assign prod   = PRW'(irst_mag) * PRW'(K_NUM);
  assign thr    = prod >> K_SH;
  assign dif_x  = PRW'(idif_mag);
  assign harm_x = PRW'(iharm_sum);

  wire trig    = sample_en & (det_ac | det_dc);
  wire above   = irst_mag > FLOOR_V;
  wire sat     = above & (dif_x > thr) & (harm_x > thr);
  wire rel     = above & (dif_x < thr) & (harm_x < thr) & evid;
  wire pk_done = sample_en & hold & rel & (pk_cnt == PW'(PICK_N - 1));
  wire cancel  = pk_done & ~trig;

  assign hold     = (short_cnt != '0) | (long_cnt != '0);
  assign long_cxl = cxl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                             short_cnt <= '0;
    else if (trig)                          short_cnt <= SW'(SHORT_N);
    else if (sample_en && short_cnt != '0)  short_cnt <= short_cnt - SW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             long_cnt <= '0;
    else if (trig)                          long_cnt <= LW'(LONG_N);
    else if (cancel)                        long_cnt <= '0;
    else if (sample_en && long_cnt != '0)   long_cnt <= long_cnt - LW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cxl_q <= 1'b0;
    else if (trig)   cxl_q <= 1'b0;
    else if (cancel) cxl_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !hold) begin
      ev_cnt <= '0;
      evid   <= 1'b0;
    end else if (sample_en) begin
      if (sat) begin
        if (ev_cnt == EW'(EVID_N - 1)) evid <= 1'b1;
        else                           ev_cnt <= ev_cnt + EW'(1);
      end else begin
        ev_cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !hold)   pk_cnt <= '0;
    else if (sample_en) begin
      if (pk_done)         pk_cnt <= '0;
      else if (rel)        pk_cnt <= pk_cnt + PW'(1);
      else                 pk_cnt <= '0;
    end
  end
endmodule

module fault_hold_chk #(
  parameter int MAG_W     = 16,
  parameter int SPC       = 64,
  parameter int SHORT_CYC = 3,
  parameter int FLOOR     = 200,
  parameter int K_NUM     = 13,
  parameter int K_SH      = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_en,
  input logic             det_ac,
  input logic             det_dc,
  input logic [MAG_W-1:0] irst_mag,
  input logic [MAG_W-1:0] idif_mag,
  input logic [MAG_W-1:0] iharm_sum,
  input logic             hold,
  input logic             long_cxl
);
  localparam int SN  = SHORT_CYC * SPC;
  localparam int CW  = $clog2(SN + 1);
  localparam int PRW = MAG_W + $clog2(K_NUM + 1);

  wire trig = sample_en & (det_ac | det_dc);
  wire [PRW-1:0] lim = (PRW'(irst_mag) * PRW'(K_NUM)) >> K_SH;
  wire small_mag = (PRW'(idif_mag) < lim) && (PRW'(iharm_sum) < lim);

  logic [CW-1:0] since;
  logic          seen;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (trig) begin
      since <= '0;
      seen  <= 1'b1;
    end else if (sample_en && since < CW'(SN)) begin
      since <= since + CW'(1);
    end
  end

  p_det_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> hold);
  p_min_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && since < CW'(SN)) |-> hold);
  p_idle_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ($stable(hold) && $stable(long_cxl)));
  p_cxl_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(long_cxl) |-> $past(irst_mag > MAG_W'(FLOOR)));
  p_cxl_small_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(long_cxl) |-> $past(small_mag));
  p_cxl_strobed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(long_cxl) |-> ($past(sample_en) && $past(hold)));
  p_cxl_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !long_cxl);
endmodule

bind fault_hold fault_hold_chk #(
  .MAG_W(MAG_W), .SPC(SPC), .SHORT_CYC(SHORT_CYC),
  .FLOOR(FLOOR), .K_NUM(K_NUM), .K_SH(K_SH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .det_ac(det_ac),
  .det_dc(det_dc), .irst_mag(irst_mag), .idif_mag(idif_mag),
  .iharm_sum(iharm_sum), .hold(hold), .long_cxl(long_cxl)
);

// File: tb/fault_hold_test.sv
module fault_hold_test;
  localparam int CLK_P = 10;
  localparam int SPC   = 4;
  localparam int SHN   = 3 * SPC;
  localparam int LGN   = 60 * SPC;
  localparam int PKN   = 3 * SPC;
  localparam int EVN   = 1 * SPC;
  localparam int FLR   = 200;

  logic clk = 1'b0;
  logic rst_n, sample_en, det_ac, det_dc;
  logic [15:0] irst_mag, idif_mag, iharm_sum;
  wire hold, long_cxl;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  fault_hold #(.MAG_W(16), .SPC(SPC), .FLOOR(FLR)) uut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .det_ac(det_ac),
    .det_dc(det_dc), .irst_mag(irst_mag), .idif_mag(idif_mag),
    .iharm_sum(iharm_sum), .hold(hold), .long_cxl(long_cxl));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mags(input int r, input int d, input int h);
    irst_mag = 16'(r); idif_mag = 16'(d); iharm_sum = 16'(h);
  endtask

  task automatic restart();
    rst_n = 0; sample_en = 1; det_ac = 0; det_dc = 0; mags(0, 0, 0);
    step(); step();
    rst_n = 1;
  endtask

  // E0 pulse, then E1..E4 saturation evidence
  task automatic pulse_and_evidence();
    det_ac = 1; step(); det_ac = 0;
    mags(1000, 200, 200);
    repeat (EVN) step();
  endtask

  function automatic int thr_of(input int r);
    return (r * 13) >> 7;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    restart();
    step();
    chk("reset hold", hold, 0);
    chk("reset long_cxl", long_cxl, 0);

    // R4: pulse without strobe ignored
    sample_en = 0; det_ac = 1; step(); det_ac = 0;
    chk("R4 unstrobed pulse", hold, 0);

    // R1 + R3 + R4: det_dc pulse, strobe every other clock
    sample_en = 1; det_dc = 1; step(); det_dc = 0;
    chk("R1 det_dc holds", hold, 1);
    n = 0;
    for (int i = 1; i < LGN; i++) begin
      sample_en = 0; step();
      if (hold !== 1'b1) n++;
      sample_en = 1; step();
      if (hold !== 1'b1) n++;
    end
    chk("R3 R4 hold across long window", n, 0);
    step();
    chk("R3 hold falls at long end", hold, 0);

    // R8: full cancel timeline
    restart(); pulse_and_evidence();
    mags(1000, 50, 50);
    repeat (PKN - 1) step();
    chk("R8 before pickup done cxl", long_cxl, 0);
    chk("R8 before pickup done hold", hold, 1);
    step();
    chk("R8 cancel sets cxl", long_cxl, 1);
    chk("R8 cancel drops hold", hold, 0);

    // R9: new pulse after cancel restarts both timers
    mags(0, 0, 0); det_ac = 1; step(); det_ac = 0;
    chk("R9 retrigger hold", hold, 1);
    chk("R9 retrigger clears cxl", long_cxl, 0);
    repeat (LGN - 1) step();
    chk("R9 long restarted", hold, 1);
    step();
    chk("R9 long restarted ends", hold, 0);

    // R2: cancel while short timer from a later pulse still runs
    restart(); pulse_and_evidence();
    mags(1000, 50, 50);
    repeat (3) step();
    det_dc = 1; step(); det_dc = 0;            // E8
    repeat (PKN - 4) step();                   // to E16
    chk("R2 cancel with short active cxl", long_cxl, 1);
    chk("R2 short keeps hold", hold, 1);
    mags(0, 0, 0);
    repeat (3) step();                         // E19
    chk("R2 short still running", hold, 1);
    step();                                    // E20
    chk("R2 short ends", hold, 0);

    // R9: pulse on the completing strobe wins
    restart(); pulse_and_evidence();
    mags(1000, 50, 50);
    repeat (PKN - 1) step();
    det_dc = 1; step(); det_dc = 0;            // E16
    chk("R9 same-edge cxl stays 0", long_cxl, 0);
    mags(0, 0, 0);
    repeat (SHN) step();
    chk("R9 same-edge long reloaded", hold, 1);

    // R8: interrupted pickup restarts
    restart(); pulse_and_evidence();
    mags(1000, 50, 50);
    repeat (PKN - 1) step();
    mags(1000, 500, 50); step();
    mags(1000, 50, 50);
    repeat (PKN - 1) step();
    chk("R8 interrupted not yet", long_cxl, 0);
    step();
    chk("R8 interrupted completes", long_cxl, 1);

    // R7: no evidence, no release
    restart();
    det_ac = 1; step(); det_ac = 0;
    mags(1000, 50, 50);
    repeat (40) step();
    chk("R7 no evidence no cancel", long_cxl, 0);
    chk("R7 no evidence hold", hold, 1);

    // R7: evidence one strobe short
    restart();
    det_ac = 1; step(); det_ac = 0;
    mags(1000, 200, 200); repeat (EVN - 1) step();
    mags(1000, 50, 50); repeat (PKN + 4) step();
    chk("R7 short evidence no cancel", long_cxl, 0);

    // R6: threshold sweep on differential and harmonic
    for (int v = 95; v <= 108; v++) begin
      restart(); pulse_and_evidence();
      mags(1000, v, 0); repeat (PKN) step();
      chk("R6 dif sweep", long_cxl, (v < thr_of(1000)) ? 1 : 0);
      restart(); pulse_and_evidence();
      mags(1000, 0, v); repeat (PKN) step();
      chk("R6 harm sweep", long_cxl, (v < thr_of(1000)) ? 1 : 0);
    end

    // R5: floor sweep
    for (int r = FLR - 2; r <= FLR + 2; r++) begin
      restart(); pulse_and_evidence();
      mags(r, 0, 0); repeat (PKN) step();
      chk("R5 floor sweep", long_cxl, (r > FLR) ? 1 : 0);
    end

    // R10: evidence discarded when hold drops
    restart(); pulse_and_evidence();
    mags(0, 0, 0);
    for (int i = 0; i < LGN + 4 && hold; i++) step();
    chk("R10 hold dropped", hold, 0);
    det_ac = 1; step(); det_ac = 0;
    mags(1000, 50, 50); repeat (PKN + 4) step();
    chk("R10 old evidence unused", long_cxl, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule